// File: doc/BRIEF.md
# Pseudo-Operation to Machine Word Expander

This block turns assembler-level pseudo-operations into real 32-bit MIPS machine words. A producer hands over one descriptor at a time: an operation kind, a destination register, a source register and a 32-bit value. The block answers with a short stream of encoded words, one, two or three long. The final word of each expansion carries a last flag.

When the value is a constant, the block picks the form itself. A value that sign-extends from 16 bits becomes one immediate instruction. A wider value is built with an upper-half load followed by an OR of the lower half. For the add-unsigned kind, a wide constant is built in register 1, which is reserved as the expansion scratch register, and is then added with a register-format instruction. Both sides use valid/ready handshakes. The input is held off while an expansion is still draining, but it may accept the next descriptor in the same cycle the final word leaves.

Top module: `pseudo_expander`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is low and in_ready is high.
- R2: Kind 0 (no-operation) produces one word, 0x00000000, with out_last high.
- R3: Kind 1 (move) produces one register-format word: opcode 0 in [31:26], rs = 0 in [25:21], rt = source in [20:16], rd = destination in [15:11], shamt 0 in [10:6], funct 0x20 in [5:0]. out_last is high.
- R4: A value is short when it lies in the signed range -32768 to 32767. Kinds 2 and 3 use their one-word form for a short value and their multi-word form otherwise.
- R5: Kind 2 (load constant) with a short value produces one immediate-format word: opcode 0x08 in [31:26], rs = 0 in [25:21], rt = destination in [20:16], value[15:0] in [15:0].
- R6: Kind 2 with a wide value produces two words. The first is opcode 0x0F, rs 0, rt = destination, with value[31:16] as the immediate. The second is opcode 0x0D, rs = rt = destination, with value[15:0] as the immediate.
- R7: Kind 3 (add unsigned constant) with a short value produces one word: opcode 0x09, rs = source, rt = destination, with value[15:0] as the immediate.
- R8: Kind 3 with a wide value produces three words. The first is opcode 0x0F, rs 0, rt 1, with value[31:16]. The second is opcode 0x0D, rs 1, rt 1, with value[15:0]. The third is register-format with rs = source, rt = 1, rd = destination and funct 0x21.
- R9: out_last is high on the final word of each expansion and low on every other word. Once the final word is taken, out_valid drops unless a new descriptor is accepted in that same cycle.
- R10: While out_valid is high and out_ready is low, out_word and out_last stay unchanged in the next cycle, and out_valid stays high.
- R11: in_ready is low whenever a word that is not the last of its expansion is being offered. In the cycle the last word is taken, in_ready is high, and a descriptor offered then is accepted with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release it synchronously to clk |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_kind | input | 2 | 0 no-op, 1 move, 2 load constant, 3 add unsigned constant |
| in_dst | input | 5 | Destination register number |
| in_src | input | 5 | Source register number (move, add unsigned) |
| in_value | input | 32 | Constant operand |
| out_valid | output | 1 | Machine word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Encoded machine word |
| out_last | output | 1 | Final word of the current expansion |

## Verification
Two events can share a single cycle: the final word of one expansion leaving on the output, and the next descriptor being accepted on the input. The bench drives its producer and its consumer as independent processes. Descriptors arrive back to back, and out_ready is mostly high with random gaps, so this overlap happens many times. The bench counts each overlap and checks that the first word of the new expansion appears in the very next cycle, in the right order and with the right encoding. It also checks that no descriptor is taken while a non-final word is still waiting.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

  localparam int WORD_W    = 32;
  localparam int REG_W     = 5;
  localparam int IMM_W     = 16;
  localparam int OPC_W     = 6;
  localparam int SHAMT_W   = 5;
  localparam int FUNCT_W   = 6;
  localparam int KIND_W    = 2;
  localparam int MAX_WORDS = 3;
  localparam int CNT_W     = $clog2(MAX_WORDS);

  localparam logic [REG_W-1:0] ZERO_REG = '0;
  localparam logic [REG_W-1:0] SCRATCH_REG = REG_W'(1);

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_ADDU = 6'h21;

  typedef enum logic [KIND_W-1:0] {
    K_NOP  = 2'd0,
    K_MOVE = 2'd1,
    K_LDC  = 2'd2,
    K_ADDC = 2'd3
  } kind_e;

  function automatic logic [WORD_W-1:0] enc_r(
    input logic [REG_W-1:0]   rs,
    input logic [REG_W-1:0]   rt,
    input logic [REG_W-1:0]   rd,
    input logic [FUNCT_W-1:0] fn
  );
    return {OPC_RTYPE, rs, rt, rd, {SHAMT_W{1'b0}}, fn};
  endfunction

  function automatic logic [WORD_W-1:0] enc_i(
    input logic [OPC_W-1:0] op,
    input logic [REG_W-1:0] rs,
    input logic [REG_W-1:0] rt,
    input logic [IMM_W-1:0] imm
  );
    return {op, rs, rt, imm};
  endfunction

endpackage

// File: rtl/pxp_range_check.sv
module pxp_range_check #(
  parameter int WIDTH  = 32,
  parameter int NARROW = 16
) (
  input  logic [WIDTH-1:0] value,
  output logic             fits
);
  localparam int TOP_N = WIDTH - NARROW + 1;

  logic [TOP_N-1:0] upper;

  // Sign-extends from NARROW bits when the upper bits and the narrow sign bit agree
  assign upper = value[WIDTH-1:NARROW-1];
  assign fits  = (&upper) | ~(|upper);
endmodule

// File: rtl/pxp_encoder.sv
module pxp_encoder
  import pxp_pkg::*;
(
  input  kind_e                            kind,
  input  logic [REG_W-1:0]                 dst,
  input  logic [REG_W-1:0]                 src,
  input  logic [WORD_W-1:0]                value,
  output logic [MAX_WORDS-1:0][WORD_W-1:0] words,
  output logic [CNT_W-1:0]                 last_idx,
  output logic                             fits
);
  logic [IMM_W-1:0] lo_half;
  logic [IMM_W-1:0] hi_half;

  assign lo_half = value[IMM_W-1:0];
  assign hi_half = value[WORD_W-1:WORD_W-IMM_W];

  pxp_range_check #(
    .WIDTH  (WORD_W),
    .NARROW (IMM_W)
  ) u_range (
    .value (value),
    .fits  (fits)
  );

  always_comb begin
    words    = '0;
    last_idx = '0;
    unique case (kind)
      K_NOP: begin
        words[0] = '0;
      end
      K_MOVE: begin
        words[0] = enc_r(ZERO_REG, src, dst, FN_ADD);
      end
      K_LDC: begin
        if (fits) begin
          words[0] = enc_i(OPC_ADDI, ZERO_REG, dst, lo_half);
        end else begin
          words[0] = enc_i(OPC_LUI, ZERO_REG, dst, hi_half);
          words[1] = enc_i(OPC_ORI, dst, dst, lo_half);
          last_idx = CNT_W'(1);
        end
      end
      K_ADDC: begin
        if (fits) begin
          words[0] = enc_i(OPC_ADDIU, src, dst, lo_half);
        end else begin
          words[0] = enc_i(OPC_LUI, ZERO_REG, SCRATCH_REG, hi_half);
          words[1] = enc_i(OPC_ORI, SCRATCH_REG, SCRATCH_REG, lo_half);
          words[2] = enc_r(src, SCRATCH_REG, dst, FN_ADDU);
          last_idx = CNT_W'(2);
        end
      end
    endcase
  end
endmodule

// File: rtl/pxp_word_queue.sv
module pxp_word_queue #(
  parameter int DEPTH = 3,
  parameter int W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DEPTH-1:0][W-1:0]   load_words,
  input  logic [$clog2(DEPTH)-1:0]  load_last,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [W-1:0]              out_word,
  output logic                      out_last,
  output logic                      done
);
  localparam int IW = $clog2(DEPTH);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q, last_d;
  logic [W-1:0]  slot_q [DEPTH];
  logic          fire;

  assign out_valid = busy_q;
  assign out_word  = slot_q[idx_q];
  assign out_last  = busy_q && (idx_q == last_q);
  assign fire      = busy_q && out_ready;
  assign done      = fire && out_last;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
      last_d = load_last;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (fire) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (load) begin
        slot_q[g] <= load_words[g];
      end
    end
  end

  // R10: an offered word that is not taken is offered again unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  // R9: after the final word leaves with no new load, the output goes idle
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !out_valid);
endmodule

// File: rtl/pseudo_expander.sv
module pseudo_expander
  import pxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src,
  input  logic [WORD_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  kind_e                            kind;
  logic [MAX_WORDS-1:0][WORD_W-1:0] enc_words;
  logic [CNT_W-1:0]                 enc_last;
  logic                             enc_fits;
  logic                             q_done;
  logic                             accept;

  assign kind     = kind_e'(in_kind);
  assign in_ready = !out_valid || q_done;
  assign accept   = in_valid && in_ready;

  pxp_encoder u_enc (
    .kind     (kind),
    .dst      (in_dst),
    .src      (in_src),
    .value    (in_value),
    .words    (enc_words),
    .last_idx (enc_last),
    .fits     (enc_fits)
  );

  pxp_word_queue #(
    .DEPTH (MAX_WORDS),
    .W     (WORD_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_words (enc_words),
    .load_last  (enc_last),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .out_last   (out_last),
    .done       (q_done)
  );

  // R11: no descriptor is taken while a non-final word waits
  p_midway_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R4: a short load constant is a single word
  p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_LDC && enc_fits) |=> (out_valid && out_last));

  // R8: a wide add constant starts by loading the scratch register
  p_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_ADDC && !enc_fits) |=>
      (out_valid && !out_last && out_word[31:26] == OPC_LUI && out_word[20:16] == SCRATCH_REG));
endmodule

// File: tb/pseudo_expander_test.sv
module pseudo_expander_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_kind;
  logic [4:0]  in_dst;
  logic [4:0]  in_src;
  logic [31:0] in_value;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  int handoffs = 0;
  int ready_pct = 10;
  bit prod_done = 0;

  logic [31:0] q_word [$];
  bit          q_last [$];
  string       q_tag  [$];

  always #5 clk = ~clk;

  pseudo_expander uut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_kind (in_kind), .in_dst (in_dst), .in_src (in_src), .in_value (in_value),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_word (out_word), .out_last (out_last)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit short16(input logic [31:0] v);
    return ($signed(v) >= -32768) && ($signed(v) <= 32767);
  endfunction

  function automatic logic [31:0] iw(input int op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op[5:0], rs, rt, imm};
  endfunction

  function automatic logic [31:0] rw(input logic [4:0] rs, rt, rd, input int fn);
    return {6'd0, rs, rt, rd, 5'd0, fn[5:0]};
  endfunction

  // Expected expansion, from R2 to R8
  task automatic push_expected(input logic [1:0] k, input logic [4:0] d, s, input logic [31:0] v);
    logic [31:0] w [3];
    int n;
    string tag;
    n = 1;
    w[0] = 32'd0; w[1] = 32'd0; w[2] = 32'd0;
    case (k)
      2'd0: begin w[0] = 32'd0; tag = "R2"; end
      2'd1: begin w[0] = rw(5'd0, s, d, 'h20); tag = "R3"; end
      2'd2: begin
        if (short16(v)) begin w[0] = iw('h08, 5'd0, d, v[15:0]); tag = "R4,R5"; end
        else begin
          w[0] = iw('h0F, 5'd0, d, v[31:16]);
          w[1] = iw('h0D, d, d, v[15:0]);
          n = 2; tag = "R4,R6";
        end
      end
      default: begin
        if (short16(v)) begin w[0] = iw('h09, s, d, v[15:0]); tag = "R4,R7"; end
        else begin
          w[0] = iw('h0F, 5'd0, 5'd1, v[31:16]);
          w[1] = iw('h0D, 5'd1, 5'd1, v[15:0]);
          w[2] = rw(s, 5'd1, d, 'h21);
          n = 3; tag = "R4,R8";
        end
      end
    endcase
    for (int i = 0; i < n; i++) begin
      q_word.push_back(w[i]);
      q_last.push_back(i == n - 1);
      q_tag.push_back(tag);
    end
  endtask

  // Caller is at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [1:0] k, input logic [4:0] d, s, input logic [31:0] v);
    bit acc;
    in_kind = k; in_dst = d; in_src = s; in_value = v; in_valid = 1'b1;
    forever begin
      #1;
      acc = in_ready;
      if (acc) push_expected(k, d, s, v);
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] pick_value();
    logic [31:0] edges [8];
    edges[0] = 32'h0000_7FFF; edges[1] = 32'hFFFF_8000;
    edges[2] = 32'h0000_8000; edges[3] = 32'hFFFF_7FFF;
    edges[4] = 32'h0000_0000; edges[5] = 32'hFFFF_FFFF;
    edges[6] = 32'h0000_FFFF; edges[7] = 32'h8000_0000;
    case ($urandom_range(0, 3))
      0: return edges[$urandom_range(0, 7)];
      1: return 32'($urandom_range(0, 65535)) - 32'd32768;
      2: return $urandom;
      default: return 32'($urandom_range(32760, 32775)) ^ ({32{$urandom_range(0, 1) == 1}});
    endcase
  endfunction

  task automatic producer();
    @(negedge clk);
    // Directed corner cases
    send(2'd0, 5'd3, 5'd4, 32'hDEAD_BEEF);
    send(2'd1, 5'd8, 5'd9, 32'd0);
    send(2'd2, 5'd10, 5'd0, 32'h0000_7FFF);
    send(2'd2, 5'd11, 5'd0, 32'hFFFF_8000);
    send(2'd2, 5'd12, 5'd0, 32'h0000_8000);
    send(2'd2, 5'd13, 5'd0, 32'hFFFF_7FFF);
    send(2'd2, 5'd14, 5'd0, 32'hABAB_CDCD);
    send(2'd3, 5'd5, 5'd5, 32'hFFFF_FFFF);
    send(2'd3, 5'd6, 5'd7, 32'h0000_8000);
    send(2'd3, 5'd15, 5'd16, 32'h1234_5678);
    send(2'd3, 5'd17, 5'd17, 32'hFFFF_8000);
    ready_pct = 7;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) == 0) @(negedge clk);
      send(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
           5'($urandom_range(0, 31)), pick_value());
    end
    prod_done = 1;
  endtask

  task automatic consumer();
    logic [31:0] held_word;
    bit held_last;
    bit held_v;
    logic [31:0] ew;
    bit el;
    string et;
    held_v = 0;
    held_word = '0;
    held_last = 0;
    while (!(prod_done && q_word.size() == 0)) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 9) < ready_pct);
      #1;
      if (held_v) begin
        check(out_valid && out_word == held_word && out_last == held_last,
              "R10 held word", out_word, held_word);
      end
      held_v = 0;
      if (out_valid && !out_last) check(!in_ready, "R11 ready low midway", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (q_word.size() == 0) begin
          check(1'b0, "R9 unexpected word", out_word, 32'd0);
        end else begin
          ew = q_word.pop_front(); el = q_last.pop_front(); et = q_tag.pop_front();
          check(out_word == ew, et, out_word, ew);
          check(out_last == el, "R9 last flag", 32'(out_last), 32'(el));
        end
        if (out_last && in_valid) begin
          check(in_ready, "R11 ready on final word", 32'(in_ready), 32'd1);
          if (in_ready) handoffs++;
        end
      end else if (out_valid) begin
        held_word = out_word; held_last = out_last; held_v = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20250601));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_kind = '0; in_dst = '0; in_src = '0; in_value = '0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready, "R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    fork
      producer();
      consumer();
    join
    repeat (2) @(negedge clk);
    #1;
    check(!out_valid, "R9 idle after drain", 32'(out_valid), 32'd0);
    check(handoffs > 0, "R11 same-cycle handoff seen", 32'(handoffs), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule